// File: doc/BRIEF.md
# Frame Job Queue Controller

This block is the control core of a camera front-end pipeline. Software stages the next frame job in a window of shadow configuration words, then issues a queue command. At the next frame start from the upstream pixel stream, the block copies the staged words into the active configuration, which the downstream stages use. It then tracks the frame through to its end. Only one job can be pending at a time. While a job is pending, the shadow words are write-protected, so the pending job cannot be changed.

Software reaches the block through a simple 32-bit register port with byte addresses. A write strobe carries the write address and data. The read data is registered and follows the read address one clock later. Progress is reported through interrupt status bits, combined with an enable mask into a single interrupt line. The status, frame, error and output registers show a snapshot taken by a latch command. Each output has a line-count threshold that raises its own interrupt partway through a frame.

Top module: `frame_job_queue`

## Requirements
- R1: After reset, the latched status, error, frame and output registers read 0, the interrupt status reads 0, and the irq output is low.
- R2: Address 0x000 reads the version word: the major revision in bits 31:24, the minor revision in bits 23:20, and zero elsewhere.
- R3: A write to the control register at 0x004 with bit 0 set queues the staged job when none is pending. The status then reads 0x3: bit 0 means pending, bit 1 means waiting for a frame start, and bit 2 means a frame is in progress.
- R4: The first frame start after a job is queued copies the shadow words (word k at 0x040+4k) to the active configuration and sets status to 0x4. It also sets interrupt status bit 1 (frame start) and bit 24 (queue ready).
- R5: A frame end during a frame sets interrupt bit 0 and increments the frame count. Status becomes 0x3 if a further job was queued during the frame, and 0 otherwise.
- R6: A queue command while a job is already pending is ignored and sets error bit 0. Shadow writes are ignored while a job is pending, so the pending job reaches the active configuration unchanged.
- R7: The low 16 bits of active word i hold the line threshold of output i (i = 0, 1). The line pulse that brings the frame's line count to that threshold sets interrupt bit 8+i and output-status bit i. A threshold of 0 never fires.
- R8: Writing ones to interrupt status (0x01C) clears those bits and leaves the others unchanged. irq is high exactly when a bit set in the interrupt status is also set in the enable register (0x018).
- R9: Addresses 0x008, 0x00C, 0x010 and 0x014 return the values captured by the last control write with bit 3 set, not live values. The frame word holds the completed-frame count in bits 15:0 and the current frame's line count in bits 31:16.
- R10: Control bit 1 (abort) clears the pending job and the frame in progress, so status is 0 from the next cycle, even mid-frame. After an abort, frame starts are ignored until a new job is queued.
- R11: Control bit 2 (reset) returns status, error flags, frame and line counts, and interrupt status to 0.
- R12: A frame start with no pending job is ignored (no interrupt, status stays 0). A frame start during a frame sets error bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write byte address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 8 | Register read byte address |
| rdData | output | 32 | Read data, registered one cycle after rdAddr |
| frameStart | input | 1 | Upstream frame-start pulse |
| frameEnd | input | 1 | Upstream frame-end pulse |
| lineValid | input | 1 | One pulse per emitted line |
| irq | output | 1 | Interrupt request |
| activeCfg | output | CFG_WORDS*32 | Active configuration, word k in bits 32k+31:32k |

## Verification
The main flow is run from a table of threshold pairs and line counts. The table covers:
- thresholds below the line count and exactly equal to it;
- a threshold above the line count;
- zero thresholds;
- a threshold of one.

Together these separate an off-by-one compare, a missing zero guard, and a swap of the two outputs. Each frame's latched frame word shows whether lines and frames are counted. Directed sequences cover the other cases:
- a double queue with a blocked shadow write;
- a frame start with no job, and one during a frame;
- a queue during a frame;
- a mid-frame abort;
- a selective write-one-to-clear under different enable masks;
- the reset command.

// File: rtl/fjq_pkg.sv
package fjq_pkg;
  localparam logic [7:0] OFS_VER  = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_FRM  = 8'h0C;
  localparam logic [7:0] OFS_ERR  = 8'h10;
  localparam logic [7:0] OFS_OUT  = 8'h14;
  localparam logic [7:0] OFS_IEN  = 8'h18;
  localparam logic [7:0] OFS_IST  = 8'h1C;
  localparam int         CFG_BASE = 64;

  localparam int CMD_QUEUE = 0;
  localparam int CMD_ABORT = 1;
  localparam int CMD_RESET = 2;
  localparam int CMD_LATCH = 3;

  localparam int IRQ_EOF   = 0;
  localparam int IRQ_SOF   = 1;
  localparam int IRQ_LINE0 = 8;
  localparam int IRQ_QRDY  = 24;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WAIT = 2'd1,
    ENG_RUN  = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic promote;
    logic sof;
    logic eof;
    logic inFrame;
    logic softRst;
    logic latch;
    logic shadowLock;
  } ctrl_strobe_t;
endpackage

// File: rtl/fjq_ctrl.sv
module fjq_ctrl
  import fjq_pkg::*;
#(
  parameter int FCNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrAddr,
  input  logic [3:0]        cmdBits,
  input  logic              frameStart,
  input  logic              frameEnd,
  output ctrl_strobe_t      strb,
  output logic [2:0]        statusBits,
  output logic [1:0]        errBits,
  output logic [FCNT_W-1:0] frameCnt
);
  eng_state_e        engSt, engN;
  logic              queued, queuedN;
  logic [1:0]        errQ, errN;
  logic [FCNT_W-1:0] fcQ, fcN;
  logic              ctrlWr, qCmd, abortCmd, rstCmd, latchCmd, accept;
  logic              promote, eofHit;

  assign ctrlWr   = wrEn && (wrAddr == OFS_CTRL);
  assign qCmd     = ctrlWr && cmdBits[CMD_QUEUE];
  assign abortCmd = ctrlWr && cmdBits[CMD_ABORT];
  assign rstCmd   = ctrlWr && cmdBits[CMD_RESET];
  assign latchCmd = ctrlWr && cmdBits[CMD_LATCH];
  assign accept   = qCmd && !queued;

  always_comb begin
    engN    = engSt;
    queuedN = queued;
    errN    = errQ;
    fcN     = fcQ;
    promote = 1'b0;
    eofHit  = 1'b0;
    if (rstCmd) begin
      engN    = ENG_IDLE;
      queuedN = 1'b0;
      errN    = '0;
      fcN     = '0;
    end else if (abortCmd) begin
      engN    = ENG_IDLE;
      queuedN = 1'b0;
    end else begin
      if (qCmd && queued) errN[0] = 1'b1;
      if (accept) queuedN = 1'b1;
      case (engSt)
        ENG_IDLE: if (accept) engN = ENG_WAIT;
        ENG_WAIT: if (frameStart) begin
          engN    = ENG_RUN;
          queuedN = 1'b0;
          promote = 1'b1;
        end
        ENG_RUN: begin
          if (frameStart) errN[1] = 1'b1;
          if (frameEnd) begin
            eofHit = 1'b1;
            fcN    = fcQ + FCNT_W'(1);
            engN   = (queued || accept) ? ENG_WAIT : ENG_IDLE;
          end
        end
        default: engN = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engSt  <= ENG_IDLE;
      queued <= 1'b0;
      errQ   <= '0;
      fcQ    <= '0;
    end else begin
      engSt  <= engN;
      queued <= queuedN;
      errQ   <= errN;
      fcQ    <= fcN;
    end
  end

  always_comb begin
    strb.promote    = promote;
    strb.sof        = promote;
    strb.eof        = eofHit;
    strb.inFrame    = (engSt == ENG_RUN);
    strb.softRst    = rstCmd;
    strb.latch      = latchCmd;
    strb.shadowLock = queued;
  end

  assign statusBits = {engSt == ENG_RUN, engSt == ENG_WAIT, queued};
  assign errBits    = errQ;
  assign frameCnt   = fcQ;

  // R3
  wait_has_job_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engSt == ENG_WAIT) |-> queued);
  // R4
  promote_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[2]) |-> $past(frameStart));
  // R5
  end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[2] && frameEnd) |=> !statusBits[2]);
  // R6
  overflow_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qCmd && queued && !abortCmd && !rstCmd) |=> (queued && errBits[0]));
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd |=> (statusBits == 3'b000));
endmodule

// File: rtl/fjq_data.sv
module fjq_data
  import fjq_pkg::*;
#(
  parameter int CFG_WORDS = 4,
  parameter int NUM_OUT   = 2,
  parameter int LINE_W    = 16,
  parameter int FCNT_W    = 16,
  parameter int VER_MAJOR = 2,
  parameter int VER_MINOR = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [7:0]             wrAddr,
  input  logic [31:0]            wrData,
  input  logic [7:0]             rdAddr,
  output logic [31:0]            rdData,
  input  logic                   lineValid,
  input  ctrl_strobe_t           strb,
  input  logic [2:0]             statusBits,
  input  logic [1:0]             errBits,
  input  logic [FCNT_W-1:0]      frameCnt,
  output logic                   irq,
  output logic [CFG_WORDS*32-1:0] activeCfg
);
  localparam logic [8:0]  CFG_END  = 9'(CFG_BASE + 4 * CFG_WORDS);
  localparam logic [31:0] VER_WORD = {8'(VER_MAJOR), 4'(VER_MINOR), 20'h0};

  logic [CFG_WORDS-1:0][31:0] shadowQ, activeQ;
  logic [LINE_W-1:0]          lineCnt, lineNext;
  logic [NUM_OUT-1:0]         hit, outReached;
  logic [31:0]                intStat, intEn, setVec, clrVec, rdNext;
  logic [31:0]                snapStat, snapFrm, snapErr, snapOut;
  logic [31:0]                frmWord;
  logic [7:0]                 cfgOff;
  logic                       cfgHit, istWr;

  assign cfgOff   = wrAddr - 8'(CFG_BASE);
  assign cfgHit   = wrEn && ({1'b0, wrAddr} >= 9'(CFG_BASE)) &&
                    ({1'b0, wrAddr} < CFG_END) && (wrAddr[1:0] == 2'b00);
  assign istWr    = wrEn && (wrAddr == OFS_IST);
  assign lineNext = lineCnt + LINE_W'(1);

  generate
    for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shadowQ[w] <= '0;
          activeQ[w] <= '0;
        end else begin
          if (cfgHit && !strb.shadowLock && (cfgOff[7:2] == 6'(w)))
            shadowQ[w] <= wrData;
          if (strb.promote)
            activeQ[w] <= shadowQ[w];
        end
      end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      logic [LINE_W-1:0] thr;
      assign thr    = activeQ[i][LINE_W-1:0];
      assign hit[i] = strb.inFrame && lineValid && (thr != '0) && (lineNext == thr);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                           outReached[i] <= 1'b0;
        else if (strb.softRst || strb.promote) outReached[i] <= 1'b0;
        else if (hit[i])                     outReached[i] <= 1'b1;
      end
    end
  endgenerate

  assign activeCfg = activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         lineCnt <= '0;
    else if (strb.softRst || strb.promote) lineCnt <= '0;
    else if (strb.inFrame && lineValid) lineCnt <= lineNext;
  end

  always_comb begin
    setVec = '0;
    setVec[IRQ_EOF]  = strb.eof;
    setVec[IRQ_SOF]  = strb.sof;
    setVec[IRQ_QRDY] = strb.promote;
    for (int i = 0; i < NUM_OUT; i++) setVec[IRQ_LINE0 + i] = hit[i];
    clrVec = istWr ? wrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStat <= '0;
      intEn   <= '0;
    end else begin
      if (strb.softRst) intStat <= '0;
      else              intStat <= (intStat & ~clrVec) | setVec;
      if (wrEn && (wrAddr == OFS_IEN)) intEn <= wrData;
    end
  end

  assign irq     = |(intStat & intEn);
  assign frmWord = 32'(frameCnt) | (32'(lineCnt) << 16);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapStat <= '0;
      snapFrm  <= '0;
      snapErr  <= '0;
      snapOut  <= '0;
    end else if (strb.softRst) begin
      snapStat <= '0;
      snapFrm  <= '0;
      snapErr  <= '0;
      snapOut  <= '0;
    end else if (strb.latch) begin
      snapStat <= 32'(statusBits);
      snapFrm  <= frmWord;
      snapErr  <= 32'(errBits);
      snapOut  <= 32'(outReached);
    end
  end

  always_comb begin
    rdNext = '0;
    case (rdAddr)
      OFS_VER:  rdNext = VER_WORD;
      OFS_STAT: rdNext = snapStat;
      OFS_FRM:  rdNext = snapFrm;
      OFS_ERR:  rdNext = snapErr;
      OFS_OUT:  rdNext = snapOut;
      OFS_IEN:  rdNext = intEn;
      OFS_IST:  rdNext = intStat;
      default: begin
        for (int w = 0; w < CFG_WORDS; w++)
          if (rdAddr == 8'(CFG_BASE + 4 * w)) rdNext = shadowQ[w];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // R4
  copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.promote |=> (activeQ == $past(shadowQ)));
  // R6
  lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shadowLock |=> $stable(shadowQ));
  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (istWr && wrData[IRQ_EOF] && !strb.eof && !strb.softRst) |=> !intStat[IRQ_EOF]);
  // R7
  line_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ[0][LINE_W-1:0] == '0) |-> !hit[0]);
endmodule

// File: rtl/frame_job_queue.sv
module frame_job_queue
  import fjq_pkg::*;
#(
  parameter int CFG_WORDS = 4,
  parameter int NUM_OUT   = 2,
  parameter int LINE_W    = 16,
  parameter int FCNT_W    = 16,
  parameter int VER_MAJOR = 2,
  parameter int VER_MINOR = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [7:0]              wrAddr,
  input  logic [31:0]             wrData,
  input  logic [7:0]              rdAddr,
  output logic [31:0]             rdData,
  input  logic                    frameStart,
  input  logic                    frameEnd,
  input  logic                    lineValid,
  output logic                    irq,
  output logic [CFG_WORDS*32-1:0] activeCfg
);
  ctrl_strobe_t      strb;
  logic [2:0]        statusBits;
  logic [1:0]        errBits;
  logic [FCNT_W-1:0] frameCnt;

  fjq_ctrl #(.FCNT_W(FCNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cmdBits(wrData[3:0]), .frameStart(frameStart), .frameEnd(frameEnd),
    .strb(strb), .statusBits(statusBits), .errBits(errBits), .frameCnt(frameCnt)
  );

  fjq_data #(
    .CFG_WORDS(CFG_WORDS), .NUM_OUT(NUM_OUT), .LINE_W(LINE_W),
    .FCNT_W(FCNT_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .lineValid(lineValid), .strb(strb),
    .statusBits(statusBits), .errBits(errBits), .frameCnt(frameCnt),
    .irq(irq), .activeCfg(activeCfg)
  );
endmodule

// File: tb/frame_job_queue_bench.sv
module frame_job_queue_bench;
  localparam int CFG_WORDS = 4;
  localparam logic [7:0] A_VER = 8'h00, A_CTRL = 8'h04, A_STAT = 8'h08, A_FRM = 8'h0C;
  localparam logic [7:0] A_ERR = 8'h10, A_OUT = 8'h14, A_IEN = 8'h18, A_IST = 8'h1C;
  localparam logic [7:0] A_CFG0 = 8'h40, A_CFG1 = 8'h44, A_CFG2 = 8'h48;
  // thr0, thr1, lines per frame
  localparam logic [47:0] VEC [6] = '{
    {16'd3, 16'd5, 16'd6},
    {16'd4, 16'd0, 16'd4},
    {16'd7, 16'd2, 16'd3},
    {16'd1, 16'd1, 16'd1},
    {16'd0, 16'd0, 16'd5},
    {16'd9, 16'd9, 16'd8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0] rdAddr = '0;
  logic [31:0] rdData;
  logic frameStart = 1'b0, frameEnd = 1'b0, lineValid = 1'b0;
  logic irq;
  logic [CFG_WORDS*32-1:0] activeCfg;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frame_job_queue u_frame_job_queue (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .frameStart(frameStart), .frameEnd(frameEnd),
    .lineValid(lineValid), .irq(irq), .activeCfg(activeCfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rdAddr = a;
    @(negedge clk); d = rdData;
  endtask

  task automatic latchRd(input logic [7:0] a, output logic [31:0] d);
    wr(A_CTRL, 32'h8);
    rd(a, d);
  endtask

  task automatic pulseFs();
    @(negedge clk); frameStart = 1'b1; @(negedge clk); frameStart = 1'b0;
  endtask
  task automatic pulseFe();
    @(negedge clk); frameEnd = 1'b1; @(negedge clk); frameEnd = 1'b0;
  endtask
  task automatic pulseLv();
    @(negedge clk); lineValid = 1'b1; @(negedge clk); lineValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R2 reset state and version
    rd(A_VER, v);  chk("R2 version", v, 32'h0250_0000);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_FRM, v);  chk("R1 frame", v, 0);
    rd(A_IST, v);  chk("R1 intstat", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R12 frame start without a job
    pulseFs();
    latchRd(A_STAT, v); chk("R12 no-job status", v, 0);
    rd(A_IST, v);       chk("R12 no-job intstat", v, 0);

    // R7 / R5 table of threshold frames
    for (int i = 0; i < 6; i++) begin
      logic [15:0] t0, t1, n;
      logic h0, h1;
      t0 = VEC[i][47:32]; t1 = VEC[i][31:16]; n = VEC[i][15:0];
      h0 = (t0 != 0) && (t0 <= n);
      h1 = (t1 != 0) && (t1 <= n);
      wr(A_IST, 32'hFFFF_FFFF);
      wr(A_CFG0, 32'hAB00_0000 | 32'(t0));
      wr(A_CFG1, 32'hCD00_0000 | 32'(t1));
      wr(A_CTRL, 32'h1);
      pulseFs();
      for (int k = 0; k < int'(n); k++) pulseLv();
      pulseFe();
      latchRd(A_IST, v);
      chk("R7 line irq bits", v, 32'h0100_0003 | (32'(h0) << 8) | (32'(h1) << 9));
      rd(A_OUT, v); chk("R7 output status", v, {30'b0, h1, h0});
      rd(A_FRM, v); chk("R5 frame word", v, (32'(n) << 16) | 32'(i + 1));
    end

    // R3 / R6 / R9 / R4 queue, double queue and blocked shadow write
    wr(A_IST, 32'hFFFF_FFFF);
    wr(A_CFG2, 32'hA5A5_0001);
    wr(A_CTRL, 32'h1);
    latchRd(A_STAT, v); chk("R3 queued status", v, 32'h3);
    wr(A_CFG2, 32'hDEAD_BEEF);
    wr(A_CTRL, 32'h1);
    rd(A_CFG2, v);      chk("R6 shadow locked", v, 32'hA5A5_0001);
    latchRd(A_ERR, v);  chk("R6 overflow error", v, 32'h1);
    pulseFs();
    rd(A_STAT, v);      chk("R9 snapshot not live", v, 32'h3);
    latchRd(A_STAT, v); chk("R4 active status", v, 32'h4);
    chk("R4 active word", activeCfg[95:64], 32'hA5A5_0001);
    rd(A_IST, v);       chk("R4 sof+qready", v, 32'h0100_0002);

    // R12 frame start during a frame
    pulseFs();
    latchRd(A_ERR, v);  chk("R12 start-in-frame error", v, 32'h3);

    // R5 queue during frame, then frame end
    wr(A_CTRL, 32'h1);
    pulseFe();
    latchRd(A_STAT, v); chk("R5 requeued status", v, 32'h3);
    rd(A_IST, v);       chk("R5 eof bit", v & 32'h1, 32'h1);

    // R10 abort mid-frame
    pulseFs();
    pulseLv();
    wr(A_CTRL, 32'h2);
    latchRd(A_STAT, v); chk("R10 abort status", v, 0);
    wr(A_IST, 32'hFFFF_FFFF);
    pulseFs();
    latchRd(A_STAT, v); chk("R10 after-abort start", v, 0);
    rd(A_IST, v);       chk("R10 no irq after abort", v, 0);

    // R8 enable mask and write-one-to-clear
    wr(A_CTRL, 32'h1);
    pulseFs();
    wr(A_IEN, 32'h0);
    chk("R8 masked irq", 32'(irq), 0);
    wr(A_IEN, 32'h0100_0000);
    chk("R8 enabled irq", 32'(irq), 1);
    wr(A_IST, 32'h0100_0000);
    chk("R8 cleared irq", 32'(irq), 0);
    rd(A_IST, v);       chk("R8 other bit kept", v, 32'h2);

    // R11 reset command
    wr(A_CTRL, 32'h4);
    latchRd(A_STAT, v); chk("R11 status", v, 0);
    rd(A_ERR, v);       chk("R11 errors", v, 0);
    rd(A_FRM, v);       chk("R11 frame word", v, 0);
    rd(A_IST, v);       chk("R11 intstat", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule